// File: doc/BRIEF.md
# Fractional-Rate Timestamp Timer with Alarm

This block keeps a free-running 64-bit timestamp that software reads over a 32-bit register port. The timestamp does not advance on every input clock. It advances at a rational fraction of that clock. A ratio register pair (a 16-bit numerator and a 16-bit denominator) sets the tick rate to f_clk * denominator / numerator. Each tick adds a fixed step to the count. The default step is 32. With a tick rate of 31.25 MHz, the count then reads directly in nanoseconds.

Software reads the timestamp as two 32-bit words. It reads the high word, then the low word, then the high word again, and retries if the two high reads differ. To make this safe, the high word changes only when the low word wraps. A 32-bit alarm is compared against the low word. Each tick is checked for whether it carried the low word onto or past the alarm value. When the alarm enable is set, such a crossing latches a status bit. The interrupt output is a level signal: it is high while that status bit is set and the alarm enable is set. Software clears the status bit by writing a 1 to it.

A small state machine drives the rate generator. It has three states:
- RATE_RESTART: the accumulator is held at zero for one cycle. This state is entered at reset and on every write to the numerator or the denominator.
- RATE_RUN: the ratio is valid, and each cycle adds the denominator to the accumulator.
- RATE_HALT: the numerator or the denominator is zero, and no ticks are produced.

The transitions are as follows:
- restart: any state goes to RATE_RESTART on a write to the numerator or the denominator.
- arm: RATE_RESTART goes to RATE_RUN when both values are non-zero.
- park: RATE_RESTART goes to RATE_HALT when either value is zero.

Top module: `frac_timer`

## Requirements
- R1: After reset, the numerator and the denominator read 1. The time low and high words read 0. Interrupt status reads 0, interrupt enable reads 0, and `irq` is low.
- R2: With a non-zero ratio and denominator ≤ numerator, exactly `den` ticks occur in every `num` consecutive clocks. Each tick adds `TICK_STEP` (default 32) to the 64-bit time.
- R3: While the numerator or the denominator is zero, the time does not change.
- R4: When denominator ≥ numerator (both non-zero), one tick occurs on every clock.
- R5: Only bits 15:0 of a numerator or denominator write are stored. Bits 31:16 read back as 0.
- R6: The time is a 64-bit count. The high word (0x410) increments by one exactly when the low word (0x400) wraps, and between consecutive clocks the 64-bit value either holds or grows by one step.
- R7: While interrupt enable bit 0 is 1, a tick that moves the low word from P to N sets status bit 0 when the alarm value A satisfies 0 < (A − P) mod 2^32 ≤ `TICK_STEP`. This includes the case A = N.
- R8: While enable bit 0 is 0, an alarm crossing does not set status bit 0.
- R9: Writing 1 to status bit 0 (0x100) clears it, and writing 0 leaves it unchanged. Writing 0xFFFFFFFF clears every status bit. A crossing in the same cycle as a clearing write takes precedence.
- R10: `irq` is high exactly while status bit 0 and enable bit 0 are both 1.
- R11: The register offsets are:

  | Offset | Register |
  |---|---|
  | 0x100 | status |
  | 0x140 | enable |
  | 0x200 | numerator |
  | 0x210 | denominator |
  | 0x400 | time low |
  | 0x410 | time high |
  | 0x420 | alarm |

  Any other address reads 0.
- R12: A write to the numerator or the denominator restarts the accumulator from zero. With ratio 1/4, the first tick lands on the fifth clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Alarm interrupt, level |

## Verification
The bench builds the block with `TICK_STEP` = 2^24 instead of 32. With that step, the low word wraps every 256 ticks. A few hundred clocks therefore cover several carries into the high word and a full sweep of the alarm against every low-word value. The large step also places the alarm value strictly between two tick positions, which exercises the crossing match rather than only exact equality. Ratios 1/3, 2/5, 4/1, 1/4 and zero ratios cover the accumulator's regular, saturated, restart and halted behaviour.

// File: rtl/frac_timer_pkg.sv
package frac_timer_pkg;

    localparam logic [11:0] OFS_STAT = 12'h100;
    localparam logic [11:0] OFS_IEN  = 12'h140;
    localparam logic [11:0] OFS_NUM  = 12'h200;
    localparam logic [11:0] OFS_DEN  = 12'h210;
    localparam logic [11:0] OFS_TLO  = 12'h400;
    localparam logic [11:0] OFS_THI  = 12'h410;
    localparam logic [11:0] OFS_ALRM = 12'h420;

    typedef enum logic [1:0] {
        RATE_RESTART = 2'd0,
        RATE_RUN     = 2'd1,
        RATE_HALT    = 2'd2
    } rate_state_e;

endpackage

// File: rtl/frac_timer_rate.sv
module frac_timer_rate
    import frac_timer_pkg::*;
#(
    parameter int RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic [RATIO_W-1:0] num,
    input  logic [RATIO_W-1:0] den,
    output logic               tick
);
    localparam int SUM_W = RATIO_W + 1;

    rate_state_e        state_q, state_d;
    logic [RATIO_W-1:0] acc_q, acc_d;
    logic [SUM_W-1:0]   sum;
    logic               ratio_ok;

    assign ratio_ok = (num != '0) && (den != '0);
    assign sum      = {1'b0, acc_q} + {1'b0, den};

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RATE_RESTART;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        tick    = 1'b0;
        unique case (state_q)
            RATE_RESTART: begin
                acc_d   = '0;
                state_d = ratio_ok ? RATE_RUN : RATE_HALT;
            end
            RATE_RUN: begin
                if (sum >= {1'b0, num}) begin
                    tick = 1'b1;
                    if (den >= num) acc_d = '0;
                    else            acc_d = RATIO_W'(sum - {1'b0, num});
                end else begin
                    acc_d = sum[RATIO_W-1:0];
                end
            end
            RATE_HALT: begin
                acc_d = '0;
            end
            default: begin
                acc_d   = '0;
                state_d = RATE_RESTART;
            end
        endcase
        if (restart) begin
            state_d = RATE_RESTART;
            acc_d   = '0;
        end
    end

endmodule

// File: rtl/frac_timer_count.sv
module frac_timer_count #(
    parameter longint unsigned TICK_STEP = 64'd32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic [31:0] alarm,
    output logic [63:0] time_q,
    output logic        hit
);
    logic [31:0] gap;

    always_ff @(posedge clk) begin
        if (rst)       time_q <= '0;
        else if (tick) time_q <= time_q + TICK_STEP;
    end

    // distance from current low word forward to the alarm value
    assign gap = alarm - time_q[31:0];
    assign hit = tick && (gap != 32'd0) && ({32'd0, gap} <= TICK_STEP);

endmodule

// File: rtl/frac_timer_regs.sv
module frac_timer_regs
    import frac_timer_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    input  logic [63:0]        time_q,
    input  logic               hit,
    output logic [31:0]        rdata,
    output logic               irq,
    output logic               restart,
    output logic [RATIO_W-1:0] num_q,
    output logic [RATIO_W-1:0] den_q,
    output logic [31:0]        alarm_q,
    output logic               en_q,
    output logic               stat_q
);
    logic sel_stat, sel_ien, sel_num, sel_den, sel_alrm;

    assign sel_stat = addr == ADDR_W'(OFS_STAT);
    assign sel_ien  = addr == ADDR_W'(OFS_IEN);
    assign sel_num  = addr == ADDR_W'(OFS_NUM);
    assign sel_den  = addr == ADDR_W'(OFS_DEN);
    assign sel_alrm = addr == ADDR_W'(OFS_ALRM);

    assign restart = we && (sel_num || sel_den);

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q   <= RATIO_W'(1);
            den_q   <= RATIO_W'(1);
            alarm_q <= '0;
            en_q    <= 1'b0;
            stat_q  <= 1'b0;
        end else begin
            if (we && sel_num)  num_q   <= wdata[RATIO_W-1:0];
            if (we && sel_den)  den_q   <= wdata[RATIO_W-1:0];
            if (we && sel_alrm) alarm_q <= wdata;
            if (we && sel_ien)  en_q    <= wdata[0];
            if (hit && en_q)                        stat_q <= 1'b1;
            else if (we && sel_stat && wdata[0])    stat_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if      (sel_stat)                     rdata = {31'd0, stat_q};
        else if (sel_ien)                      rdata = {31'd0, en_q};
        else if (sel_num)                      rdata = 32'(num_q);
        else if (sel_den)                      rdata = 32'(den_q);
        else if (addr == ADDR_W'(OFS_TLO))     rdata = time_q[31:0];
        else if (addr == ADDR_W'(OFS_THI))     rdata = time_q[63:32];
        else if (sel_alrm)                     rdata = alarm_q;
    end

    assign irq = stat_q & en_q;

endmodule

// File: rtl/frac_timer.sv
module frac_timer #(
    parameter int              ADDR_W    = 12,
    parameter int              RATIO_W   = 16,
    parameter longint unsigned TICK_STEP = 64'd32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    logic               tick, hit, restart, en_q, stat_q;
    logic [RATIO_W-1:0] num_q, den_q;
    logic [31:0]        alarm_q;
    logic [63:0]        time_q;

    frac_timer_rate #(.RATIO_W(RATIO_W)) u_rate (
        .clk(clk), .rst(rst), .restart(restart),
        .num(num_q), .den(den_q), .tick(tick)
    );

    frac_timer_count #(.TICK_STEP(TICK_STEP)) u_count (
        .clk(clk), .rst(rst), .tick(tick), .alarm(alarm_q),
        .time_q(time_q), .hit(hit)
    );

    frac_timer_regs #(.ADDR_W(ADDR_W), .RATIO_W(RATIO_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .time_q(time_q), .hit(hit), .rdata(reg_rdata), .irq(irq),
        .restart(restart), .num_q(num_q), .den_q(den_q), .alarm_q(alarm_q),
        .en_q(en_q), .stat_q(stat_q)
    );

endmodule

// File: rtl/frac_timer_chk.sv
module frac_timer_chk #(
    parameter int              ADDR_W    = 12,
    parameter int              RATIO_W   = 16,
    parameter longint unsigned TICK_STEP = 64'd32
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [31:0]        reg_wdata,
    input logic [63:0]        time_q,
    input logic [RATIO_W-1:0] num_q,
    input logic [RATIO_W-1:0] den_q,
    input logic               hit,
    input logic               en_q,
    input logic               stat_q,
    input logic               irq
);
    // R6
    time_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (time_q == $past(time_q)) || (time_q == $past(time_q) + TICK_STEP));

    // R3
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (num_q == '0 || den_q == '0) |=> $stable(time_q));

    // R8
    stat_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q) |-> $past(en_q));

    // R9
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_W'(12'h100) && reg_wdata[0] && !(hit && en_q)) |=> !stat_q);

    // R10
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_q && en_q));

endmodule

bind frac_timer frac_timer_chk #(
    .ADDR_W(ADDR_W), .RATIO_W(RATIO_W), .TICK_STEP(TICK_STEP)
) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .time_q(time_q), .num_q(num_q), .den_q(den_q), .hit(hit),
    .en_q(en_q), .stat_q(stat_q), .irq(irq)
);

// File: tb/test_frac_timer.sv
module test_frac_timer;
    localparam int              CLK_PERIOD = 10;
    localparam longint unsigned S          = 64'd1 << 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_timer #(.ADDR_W(12), .RATIO_W(16), .TICK_STEP(S)) i_frac_timer (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic rd_time(output logic [63:0] t);
        logic [31:0] lo, hi;
        rd(12'h400, lo); rd(12'h410, hi);
        t = {hi, lo};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rate_window(input string req, input int cycles, input longint unsigned ticks);
        logic [63:0] t0, t1;
        idle(5);
        rd_time(t0); idle(cycles); rd_time(t1);
        check(req, t1 - t0, ticks * S);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(12'h200, d); check("R1 num", 64'(d), 64'd1);
        rd(12'h210, d); check("R1 den", 64'(d), 64'd1);
        rd(12'h400, d); check("R1 tlo", 64'(d), 64'd0);
        rd(12'h410, d); check("R1 thi", 64'(d), 64'd0);
        rd(12'h100, d); check("R1 stat", 64'(d), 64'd0);
        rd(12'h140, d); check("R1 ien", 64'(d), 64'd0);
        check("R1 irq", 64'(irq), 64'd0);
    endtask

    task automatic t_rate;
        logic [31:0] d;
        wr(12'h210, 1); wr(12'h200, 3);
        rate_window("R2 ratio 1/3", 30, 10);
        wr(12'h210, 2); wr(12'h200, 5);
        rate_window("R2 ratio 2/5", 50, 20);
        wr(12'h210, 32'hABCD_0001); wr(12'h200, 32'h0001_0003);
        rd(12'h200, d); check("R5 num upper bits", 64'(d), 64'd3);
        rd(12'h210, d); check("R5 den upper bits", 64'(d), 64'd1);
        rate_window("R5 truncated ratio", 30, 10);
    endtask

    task automatic t_restart;
        logic [63:0] t0, t1;
        wr(12'h210, 1); wr(12'h200, 4);
        rd_time(t0); idle(4); rd_time(t1);
        check("R12 no tick before fifth edge", t1, t0);
        idle(1); rd_time(t1);
        check("R12 tick on fifth edge", t1, t0 + S);
    endtask

    task automatic t_zero;
        wr(12'h200, 0);
        rate_window("R3 num zero", 20, 0);
        wr(12'h200, 1); wr(12'h210, 0);
        rate_window("R3 den zero", 20, 0);
    endtask

    task automatic t_fast;
        wr(12'h200, 1); wr(12'h210, 4);
        rate_window("R4 den above num", 10, 10);
    endtask

    task automatic t_wrap;
        logic [63:0] prev, cur;
        int bad = 0;
        wr(12'h210, 1); wr(12'h200, 1);
        rd_time(prev);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            rd_time(cur);
            if (!(cur == prev || cur == prev + S)) bad++;
            if ((cur[31:0] < prev[31:0]) != (cur[63:32] == prev[63:32] + 1)) bad++;
            if (cur[63:32] != prev[63:32] && cur[63:32] != prev[63:32] + 1) bad++;
            prev = cur;
        end
        check("R6 carry into high word", 64'(bad), 64'd0);
        check("R6 high word advanced", 64'(prev[63:32] >= 32'd2), 64'd1);
    endtask

    task automatic arm_alarm(input logic [31:0] offs, input logic en);
        logic [63:0] t;
        wr(12'h200, 0);
        rd_time(t);
        wr(12'h420, t[31:0] + offs);
        wr(12'h140, {31'd0, en});
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h210, 1);
        wr(12'h200, 1);
    endtask

    task automatic t_alarm;
        logic [31:0] d;
        arm_alarm(32'(2*S + 7), 1'b1);
        idle(3); rd(12'h100, d); check("R7 no match before crossing", 64'(d), 64'd0);
        idle(1); rd(12'h100, d); check("R7 crossing sets status", 64'(d), 64'd1);
        check("R10 irq with status and enable", 64'(irq), 64'd1);
        arm_alarm(32'(2*S), 1'b1);
        idle(2); rd(12'h100, d); check("R7 exact not yet", 64'(d), 64'd0);
        idle(1); rd(12'h100, d); check("R7 exact equality", 64'(d), 64'd1);
        wr(12'h200, 0);
        rd(12'h420, d); check("R11 alarm readable", 64'(d != 0), 64'd1);
    endtask

    task automatic t_mask_w1c;
        logic [31:0] d;
        wr(12'h140, 0);
        check("R10 irq masked", 64'(irq), 64'd0);
        rd(12'h100, d); check("R10 status kept while masked", 64'(d), 64'd1);
        wr(12'h140, 1);
        check("R10 irq unmasked", 64'(irq), 64'd1);
        rd(12'h140, d); check("R11 enable readback", 64'(d), 64'd1);
        wr(12'h100, 0);
        rd(12'h100, d); check("R9 write zero no effect", 64'(d), 64'd1);
        wr(12'h100, 1);
        rd(12'h100, d); check("R9 write one clears", 64'(d), 64'd0);
        check("R9 irq drops", 64'(irq), 64'd0);
    endtask

    task automatic t_gate;
        logic [31:0] d;
        arm_alarm(32'(S), 1'b0);
        idle(300);
        rd(12'h100, d); check("R8 disabled alarm ignored", 64'(d), 64'd0);
        check("R8 irq low", 64'(irq), 64'd0);
        wr(12'h140, 1);
        idle(300);
        wr(12'h200, 0);
        rd(12'h100, d); check("R7 full sweep hits alarm", 64'(d), 64'd1);
        wr(12'h100, 32'hFFFF_FFFF);
        rd(12'h100, d); check("R9 all-ones clears", 64'(d), 64'd0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        rd(12'h300, d); check("R11 unmapped read", 64'(d), 64'd0);
        rd(12'h104, d); check("R11 near-miss read", 64'(d), 64'd0);
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        idle(3);
        t_reset();
        rst = 1'b0;
        idle(2);
        t_rate();
        t_restart();
        t_zero();
        t_fast();
        t_wrap();
        t_alarm();
        t_mask_w1c();
        t_gate();
        t_unmapped();
        report();
    end

endmodule